// File: doc/BRIEF.md
# Three-Phase Dead-Time Inserter

This block sits between a commutation controller and the gate drivers of three half-bridges. For every phase it takes the requested high-side and low-side drive levels and turns them into gate commands. Whenever one switch of a phase turns off, the opposite switch of that phase may not turn on until a dead interval has passed. This keeps both transistors of a leg from conducting at the same time.

Turn-offs reach the gates in the same cycle as the request. Only turn-ons are held back. One dead-time setting, picked by a two-bit mode input, applies to all three phases:
- a hard minimum,
- an explicit count that is never allowed below that minimum,
- a long default.

A global enable, when low, drops every gate in the same cycle and clears the dead-time timers of all phases.

Top module: `dead_time_gen`

## Requirements
- R1: While reset is asserted, and after reset with no request, every gate output is low.
- R2: A phase whose high and low requests are both 1 drives both of its gates low.
- R3: A gate goes low combinationally in the same cycle its request falls, with no clock edge needed.
- R4: After a gate of a phase goes low, the other gate of that phase rises at the earliest on the DT+1-th rising edge after the request change, counting that edge as 1. The gates of a phase never rise together with, or overlap, each other.
- R5: With dt_mode = 2'b00, DT equals the MIN_DT parameter (default 8 cycles).
- R6: With dt_mode = 2'b01, DT equals dt_val. A dt_val below MIN_DT is raised to MIN_DT.
- R7: With dt_mode = 2'b10 or 2'b11, DT equals the DEF_DT parameter (default 1500 cycles).
- R8: A gate that turns back on after its own turn-off, with no turn-on of the opposite gate in between, is not delayed. This also applies to the first turn-on after reset. The gate rises on the first rising edge after the request.
- R9: A new turn-off inside a running dead interval restarts the timer. The full DT then applies from that turn-off.
- R10: With en low, all gates are low in the same cycle. The timers are cleared, so the first turn-on after en returns high rises on the first edge.
- R11: The phases time their dead intervals independently, all using the one shared setting.
- R12: gate_hi[p] and gate_lo[p] are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Global enable; low forces all gates low |
| dt_mode | input | 2 | 00 minimum, 01 programmed count, 1x default |
| dt_val | input | CNT_W | Programmed dead time in cycles |
| req_hi | input | N_PH | Requested high-side level per phase |
| req_lo | input | N_PH | Requested low-side level per phase |
| gate_hi | output | N_PH | High-side gate command per phase |
| gate_lo | output | N_PH | Low-side gate command per phase |

## Verification
The complementary handover is driven in both directions under each mode, with a programmed value both above and below the minimum. The edge count to the rising gate tells the three dead-time sources and the clamp apart.

A drop-and-return on the same side shows that no dead time is added without a complementary turn-on. A bounce back inside a running interval, followed by a fresh handover, shows whether the timer restarts or keeps its old count.

Simultaneous requests, disabling mid-interval, and opposite handovers on two phases in the same cycle separate the conflict masking, the timer clearing and the per-phase independence.

// File: rtl/dead_time_gen.sv
module dead_time_gen #(
  parameter int N_PH   = 3,
  parameter int CNT_W  = 11,
  parameter int MIN_DT = 8,
  parameter int DEF_DT = 1500
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [1:0]       dt_mode,
  input  logic [CNT_W-1:0] dt_val,
  input  logic [N_PH-1:0]  req_hi,
  input  logic [N_PH-1:0]  req_lo,
  output logic [N_PH-1:0]  gate_hi,
  output logic [N_PH-1:0]  gate_lo
);
  localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_DT);
  localparam logic [CNT_W-1:0] DEF_C = CNT_W'(DEF_DT);
  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

  logic [CNT_W-1:0] dt_sel;

  always_comb begin
    case (dt_mode)
      2'b00:   dt_sel = MIN_C;
      2'b01:   dt_sel = (dt_val < MIN_C) ? MIN_C : dt_val;
      default: dt_sel = DEF_C;
    endcase
  end

  for (genvar p = 0; p < N_PH; p++) begin : g_ph
    logic             hq, lq, last_hi;
    logic [CNT_W-1:0] tmr;
    logic             want_h, want_l, quiet, fell_h, fell_l, go_h, go_l;

    assign want_h = req_hi[p] & ~req_lo[p];
    assign want_l = req_lo[p] & ~req_hi[p];
    assign gate_hi[p] = en & hq & want_h;
    assign gate_lo[p] = en & lq & want_l;

    assign quiet  = (tmr <= ONE_C);
    assign fell_h = hq & ~gate_hi[p];
    assign fell_l = lq & ~gate_lo[p];
    assign go_h   = want_h & ~lq & (quiet | last_hi);
    assign go_l   = want_l & ~hq & (quiet | ~last_hi);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hq      <= 1'b0;
        lq      <= 1'b0;
        last_hi <= 1'b0;
        tmr     <= '0;
      end else if (!en) begin
        hq  <= 1'b0;
        lq  <= 1'b0;
        tmr <= '0;
      end else begin
        hq <= gate_hi[p] | go_h;
        lq <= gate_lo[p] | go_l;
        if (fell_h | fell_l) begin
          tmr     <= dt_sel;
          last_hi <= fell_h;
        end else if (tmr != '0) begin
          tmr <= tmr - ONE_C;
        end
      end
    end
  end
endmodule

// File: rtl/dead_time_gen_chk.sv
module dead_time_gen_chk #(
  parameter int N_PH = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            en,
  input logic [N_PH-1:0] req_hi,
  input logic [N_PH-1:0] req_lo,
  input logic [N_PH-1:0] gate_hi,
  input logic [N_PH-1:0] gate_lo
);
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_hi & gate_lo) == '0); // R12
  AST_CONFLICT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_hi & req_lo) & (gate_hi | gate_lo)) == '0); // R2
  AST_OFF_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((gate_hi & ~req_hi) | (gate_lo & ~req_lo)) == '0); // R3
  AST_DISABLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (gate_hi | gate_lo) == '0); // R10
  AST_LO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ((gate_lo & ~$past(gate_lo)) & $past(gate_hi)) == '0); // R4
  AST_HI_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ((gate_hi & ~$past(gate_hi)) & $past(gate_lo)) == '0); // R4
endmodule

bind dead_time_gen dead_time_gen_chk #(.N_PH(N_PH)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .req_hi(req_hi), .req_lo(req_lo),
  .gate_hi(gate_hi), .gate_lo(gate_lo)
);

// File: tb/sim_dead_time_gen.sv
`timescale 1ns/1ps
module sim_dead_time_gen;
  localparam int N_PH = 3, CNT_W = 11, MIN_DT = 8, DEF_DT = 1500;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [1:0] dt_mode = 2'b00;
  logic [CNT_W-1:0] dt_val = '0;
  logic [N_PH-1:0] req_hi = '0, req_lo = '0;
  logic [N_PH-1:0] gate_hi, gate_lo;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dead_time_gen #(.N_PH(N_PH), .CNT_W(CNT_W), .MIN_DT(MIN_DT), .DEF_DT(DEF_DT)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .dt_mode(dt_mode), .dt_val(dt_val),
    .req_hi(req_hi), .req_lo(req_lo), .gate_hi(gate_hi), .gate_lo(gate_lo));

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic setp(input int ph, input bit h, input bit l);
    req_hi[ph] = h;
    req_lo[ph] = l;
  endtask

  task automatic meas(input int ph, input bit lo, output int n);
    n = 0;
    for (int k = 0; k < 3000; k++) begin
      @(posedge clk);
      @(negedge clk);
      n = k + 1;
      if (lo ? gate_lo[ph] : gate_hi[ph]) break;
    end
  endtask

  task automatic edges(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic t_reset;
    #1;
    chk("R1 reset gates", int'({gate_hi, gate_lo}), 0);
    @(negedge clk); rst_n = 1'b1; en = 1'b1;
    edges(2);
    chk("R1 idle gates", int'({gate_hi, gate_lo}), 0);
  endtask

  task automatic t_min;
    int n;
    dt_mode = 2'b00;
    setp(0, 1, 0); meas(0, 0, n); chk("R8 first turn-on", n, 1);
    setp(0, 0, 1); #1;
    chk("R3 hi drops at once", int'(gate_hi[0]), 0);
    meas(0, 1, n); chk("R5 R4 min dead time", n, MIN_DT + 1);
  endtask

  task automatic t_prog;
    int n;
    dt_mode = 2'b01; dt_val = 20;
    setp(0, 1, 0); #1;
    chk("R3 lo drops at once", int'(gate_lo[0]), 0);
    meas(0, 0, n); chk("R6 programmed 20", n, 21);
    dt_val = 3;
    setp(0, 0, 1); meas(0, 1, n); chk("R6 clamp to min", n, MIN_DT + 1);
  endtask

  task automatic t_def;
    int n;
    dt_mode = 2'b10;
    setp(0, 1, 0); meas(0, 0, n); chk("R7 default mode 10", n, DEF_DT + 1);
    dt_mode = 2'b11;
    setp(0, 0, 1); meas(0, 1, n); chk("R7 default mode 11", n, DEF_DT + 1);
  endtask

  task automatic t_same;
    int n;
    dt_mode = 2'b01; dt_val = 20;
    setp(0, 1, 0); meas(0, 0, n); chk("R6 handover to hi", n, 21);
    setp(0, 0, 0); edges(3);
    chk("R3 both idle", int'(gate_hi[0] | gate_lo[0]), 0);
    setp(0, 1, 0); meas(0, 0, n); chk("R8 same side no delay", n, 1);
  endtask

  task automatic t_restart;
    int n;
    setp(0, 0, 1); edges(5);
    chk("R4 lo held in interval", int'(gate_lo[0]), 0);
    setp(0, 1, 0); meas(0, 0, n); chk("R8 return to hi", n, 1);
    setp(0, 0, 1); meas(0, 1, n); chk("R9 timer restarted", n, 21);
  endtask

  task automatic t_conflict;
    int n;
    setp(0, 1, 1); #1;
    chk("R2 conflict at once", int'({gate_hi[0], gate_lo[0]}), 0);
    edges(30);
    chk("R2 conflict held", int'({gate_hi[0], gate_lo[0]}), 0);
    setp(0, 0, 1); meas(0, 1, n); chk("R8 lo back after conflict", n, 1);
  endtask

  task automatic t_disable;
    int n;
    setp(0, 1, 0); edges(1);
    en = 1'b0; #1;
    chk("R10 disable gates low", int'({gate_hi, gate_lo}), 0);
    edges(3);
    en = 1'b1;
    meas(0, 0, n); chk("R10 timer cleared", n, 1);
  endtask

  task automatic t_phases;
    int n;
    setp(1, 1, 0); setp(2, 0, 1);
    meas(1, 0, n); chk("R11 ph1 first on", n, 1);
    chk("R11 ph2 first on", int'(gate_lo[2]), 1);
    setp(1, 0, 1); setp(2, 1, 0);
    meas(1, 1, n); chk("R11 ph1 handover", n, 21);
    chk("R11 ph2 handover same edge", int'(gate_hi[2]), 1);
    chk("R11 ph0 untouched", int'({gate_hi[0], gate_lo[0]}), 2);
    chk("R12 no overlap", int'(gate_hi & gate_lo), 0);
  endtask

  initial begin
    t_reset;
    t_min;
    t_prog;
    t_def;
    t_same;
    t_restart;
    t_conflict;
    t_disable;
    t_phases;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule